// File: doc/BRIEF.md
# Source-Select Fractional Clock Divider

This block makes a peripheral clock in the form of a stream of single-cycle clock-enable pulses on a shared fast clock. Up to sixteen candidate sources arrive as enable strobes on that same clock. A control register picks one of them. A divide register holds a fixed-point ratio with `INT_BITS` integer bits and `FRAC_BITS` fraction bits, and the strobes of the chosen source are thinned by that ratio. Both widths are set per instance.

The division is done by a first-order accumulator. Each selected strobe adds `2^FRAC_BITS`. When the running total reaches or passes the divisor, one output pulse is emitted and the divisor is subtracted. Over a long run, the output rate is the source rate times `2^FRAC_BITS` divided by the divisor. An instance with both widths set to zero has no divider at all and forwards the chosen source unchanged. Source 0 is tied to ground inside the block. Source 1 is intended for the crystal oscillator and sources 2 and 3 for test clocks. Higher indices are free for each instance.

Software writes two 32-bit registers through a simple write strobe and reads them back on two parallel read buses. A read-only status bit in the control register shows whether the generator is running.

Top module: `fdiv_clkgen`

## Requirements
- R1: After reset, both read buses show zero and `clk_en_out` stays low.
- R2: Control bits [3:0] select the source. Strobes on any source that is not selected have no effect on the output.
- R3: Control bit 4 is the enable. Once the enable register is clear, `clk_en_out` carries no pulse in the following cycle or later.
- R4: Control bit 7 is a read-only running flag. It shows the value the enable bit held one cycle earlier, and writes to bit 7 are ignored.
- R5: The divisor is held in divide-register bits [12+INT_BITS-1 : 12-FRAC_BITS], read as integer:fraction. All other divide-register bits read as zero.
- R6: With a divider present and a divisor of zero, no output pulse is produced.
- R7: When INT_BITS and FRAC_BITS are both zero, every strobe of the enabled, selected source gives one pulse one cycle later. The divide register then reads zero and has no effect.
- R8: Source index 0 is ground. Selecting it yields no pulses, whatever strobes arrive on input bit 0.
- R9: Starting from an empty accumulator, N selected strobes with divisor D give floor(N*2^FRAC_BITS/D) pulses. Each pulse appears in the cycle after the strobe that carried the total to D or beyond.
- R10: A divisor no greater than 2^FRAC_BITS gives one pulse for every selected strobe.
- R11: A write to the divide register, or a control write that changes the source field, empties the accumulator. A strobe in the same cycle still produces its pulse, judged on the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | NUM_SRC | One enable strobe per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects divide |
| wr_data | input | 32 | Write data |
| ctl_rdata | output | 32 | Control register read-back |
| div_rdata | output | 32 | Divide register read-back |
| clk_en_out | output | 1 | Divided clock-enable pulse stream |

## Verification
Two things can happen in the same cycle: a configuration write that empties the accumulator, and a source strobe that would fire a pulse. The bench provokes this by driving a divide-register write together with the strobe that carries the total past the divisor. A correct design must emit exactly that pulse and must also discard the leftover remainder. This is judged by counting pulses over the next strobes: with the remainder kept, one pulse too many would appear. A second case changes the source field between strobes and confirms that the partial total does not carry over to the new source.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int CTL_SRC_LSB  = 0;
  localparam int CTL_EN_BIT   = 4;
  localparam int CTL_RUN_BIT  = 7;
  localparam int DIV_INT_LSB  = 12;

  typedef enum logic {
    REG_CTL = 1'b0,
    REG_DIV = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/fdiv_regs.sv
module fdiv_regs
  import fdiv_pkg::*;
#(
  parameter int NUM_SRC   = 16,
  parameter int INT_BITS  = 4,
  parameter int FRAC_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_addr,
  input  logic [31:0]           wr_data,
  output logic [SRC_W-1:0]      src_sel,
  output logic                  enable,
  output logic [DW_S-1:0]       divisor,
  output logic                  acc_clear,
  output logic [31:0]           ctl_rdata,
  output logic [31:0]           div_rdata
);
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int DIVW   = INT_BITS + FRAC_BITS;
  localparam int DW_S   = (DIVW > 0) ? DIVW : 1;
  localparam int DIV_LO = DIV_INT_LSB - FRAC_BITS;

  logic [SRC_W-1:0] src_q, src_d;
  logic             en_q, en_d;
  logic             run_q;
  logic [DW_S-1:0]  div_q, div_d;
  logic [DW_S-1:0]  div_field;
  logic             ctl_wr, div_wr;
  logic             unused_wr;

  assign unused_wr = ^wr_data;
  assign ctl_wr    = wr_en && (reg_sel_e'(wr_addr) == REG_CTL);
  assign div_wr    = wr_en && (reg_sel_e'(wr_addr) == REG_DIV);
  assign div_field = (DIVW > 0) ? wr_data[DIV_LO +: DW_S] : '0;

  // next-state
  always_comb begin
    src_d     = src_q;
    en_d      = en_q;
    div_d     = div_q;
    acc_clear = 1'b0;
    if (ctl_wr) begin
      src_d = wr_data[CTL_SRC_LSB +: SRC_W];
      en_d  = wr_data[CTL_EN_BIT];
      if (wr_data[CTL_SRC_LSB +: SRC_W] != src_q) acc_clear = 1'b1;
    end
    if (div_wr) begin
      div_d     = div_field;
      acc_clear = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      en_q  <= 1'b0;
      div_q <= '0;
      run_q <= 1'b0;
    end else begin
      src_q <= src_d;
      en_q  <= en_d;
      div_q <= div_d;
      run_q <= en_q;
    end
  end

  always_comb begin
    ctl_rdata                          = '0;
    ctl_rdata[CTL_SRC_LSB +: SRC_W]    = src_q;
    ctl_rdata[CTL_EN_BIT]              = en_q;
    ctl_rdata[CTL_RUN_BIT]             = run_q;
    div_rdata                          = '0;
    if (DIVW > 0) div_rdata[DIV_LO +: DW_S] = div_q;
  end

  assign src_sel = src_q;
  assign enable  = en_q;
  assign divisor = div_q;
endmodule

// File: rtl/fdiv_src_sel.sv
module fdiv_src_sel #(
  parameter int NUM_SRC = 16,
  parameter int SRC_W   = 4
) (
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SRC_W-1:0]   src_sel,
  output logic               tick
);
  localparam logic [NUM_SRC-1:0] GND_MASK = NUM_SRC'(1);

  logic [NUM_SRC-1:0] live;
  assign live = src_tick & ~GND_MASK;

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_sel == SRC_W'(i)) tick = live[i];
    end
  end
endmodule

// File: rtl/fdiv_accum.sv
module fdiv_accum #(
  parameter int INT_BITS  = 4,
  parameter int FRAC_BITS = 4,
  parameter int DW_S      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            enable,
  input  logic [DW_S-1:0] divisor,
  input  logic            acc_clear,
  output logic            pulse
);
  localparam int DIVW = INT_BITS + FRAC_BITS;

  logic fire;
  logic out_q;

  generate
    if (DIVW == 0) begin : g_bypass
      logic unused_cfg;
      assign unused_cfg = ^{divisor, acc_clear};
      always_comb fire = tick && enable;
    end else begin : g_divide
      localparam int ACC_W = DIVW + 1;
      localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << FRAC_BITS;

      logic [ACC_W-1:0] acc_q, acc_d;
      logic [ACC_W-1:0] sum;
      logic [ACC_W-1:0] div_ext;

      assign div_ext = {1'b0, divisor};
      assign sum     = acc_q + STEP;

      always_comb begin
        acc_d = acc_q;
        fire  = 1'b0;
        if (!enable || (divisor == '0)) begin
          acc_d = '0;
        end else if (tick) begin
          if (div_ext <= STEP) begin
            fire  = 1'b1;
            acc_d = '0;
          end else if (sum >= div_ext) begin
            fire  = 1'b1;
            acc_d = sum - div_ext;
          end else begin
            acc_d = sum;
          end
        end
        if (acc_clear) acc_d = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= fire;
  end

  assign pulse = out_q;
endmodule

// File: rtl/fdiv_clkgen.sv
module fdiv_clkgen #(
  parameter int NUM_SRC   = 16,
  parameter int INT_BITS  = 4,
  parameter int FRAC_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [31:0]        wr_data,
  output logic [31:0]        ctl_rdata,
  output logic [31:0]        div_rdata,
  output logic               clk_en_out
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int DIVW  = INT_BITS + FRAC_BITS;
  localparam int DW_S  = (DIVW > 0) ? DIVW : 1;

  logic             rst_meta, rst_int;
  logic [SRC_W-1:0] src_sel;
  logic             enable;
  logic [DW_S-1:0]  divisor;
  logic             acc_clear;
  logic             tick;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  fdiv_regs #(
    .NUM_SRC(NUM_SRC), .INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS)
  ) u_regs (
    .clk(clk), .rst_n(rst_int),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .src_sel(src_sel), .enable(enable), .divisor(divisor),
    .acc_clear(acc_clear), .ctl_rdata(ctl_rdata), .div_rdata(div_rdata)
  );

  fdiv_src_sel #(
    .NUM_SRC(NUM_SRC), .SRC_W(SRC_W)
  ) u_sel (
    .src_tick(src_tick), .src_sel(src_sel), .tick(tick)
  );

  fdiv_accum #(
    .INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS), .DW_S(DW_S)
  ) u_acc (
    .clk(clk), .rst_n(rst_int), .tick(tick), .enable(enable),
    .divisor(divisor), .acc_clear(acc_clear), .pulse(clk_en_out)
  );
endmodule

// File: rtl/fdiv_clkgen_chk.sv
module fdiv_clkgen_chk
  import fdiv_pkg::*;
#(
  parameter int NUM_SRC   = 16,
  parameter int INT_BITS  = 4,
  parameter int FRAC_BITS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_tick,
  input logic [31:0]        ctl_rdata,
  input logic [31:0]        div_rdata,
  input logic               clk_en_out
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int DIVW  = INT_BITS + FRAC_BITS;

  logic [SRC_W-1:0] sel;
  assign sel = ctl_rdata[CTL_SRC_LSB +: SRC_W];

  a_r4_run_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[CTL_RUN_BIT] == $past(ctl_rdata[CTL_EN_BIT]));

  a_r3_off_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[CTL_EN_BIT] |=> !clk_en_out);

  a_r6_zero_divisor_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((DIVW > 0) && (div_rdata == 32'd0)) |=> !clk_en_out);

  a_r8_ground_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |=> !clk_en_out);

  a_r9_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_out |-> $past(src_tick[sel]));

  a_r7_bypass_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ((DIVW == 0) && ctl_rdata[CTL_EN_BIT] && (sel != '0))
      |=> (clk_en_out == $past(src_tick[sel])));
endmodule

bind fdiv_clkgen fdiv_clkgen_chk #(
  .NUM_SRC(NUM_SRC), .INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
  .ctl_rdata(ctl_rdata), .div_rdata(div_rdata), .clk_en_out(clk_en_out)
);

// File: tb/fdiv_clkgen_test.sv
module fdiv_clkgen_test;
  localparam int NS = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_tick;
  logic          wr_en, wr_addr;
  logic [31:0]   wr_data;
  logic [31:0]   ctl_rd, div_rd, ctl_rd_b, div_rd_b;
  logic          out_m, out_b;

  int checks = 0;
  int errors = 0;
  int cnt_m  = 0;
  int cnt_b  = 0;

  always #10 clk = ~clk;

  fdiv_clkgen uut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ctl_rdata(ctl_rd),
    .div_rdata(div_rd), .clk_en_out(out_m));

  fdiv_clkgen #(.INT_BITS(0), .FRAC_BITS(0)) uut_byp (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ctl_rdata(ctl_rd_b),
    .div_rdata(div_rd_b), .clk_en_out(out_b));

  always @(negedge clk) begin
    if (out_m) cnt_m++;
    if (out_b) cnt_b++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ticks(input int idx, input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      src_tick = NS'(1) << idx;
      @(negedge clk);
      src_tick = '0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    cnt_m = 0; cnt_b = 0;
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk("R1 ctl", ctl_rd, 32'h0);
    chk("R1 div", div_rd, 32'h0);
    chk("R1 out count", cnt_m, 0);
  endtask

  task automatic t_zero_div();
    wr(1'b0, 32'h0000_0011);
    settle();
    chk("R4 running flag set", ctl_rd, 32'h91);
    ticks(1, 20, 1);
    repeat (2) @(negedge clk);
    chk("R6 zero divisor", cnt_m, 0);
    chk("R7 bypass count", cnt_b, 20);
    chk("R7 bypass div reads zero", div_rd_b, 32'h0);
    wr(1'b0, 32'h0000_0081);
    settle();
    chk("R4 run bit not writable", ctl_rd, 32'h01);
    wr(1'b0, 32'h0000_0011);
  endtask

  task automatic t_fields();
    wr(1'b1, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R5 field mask", div_rd, 32'h0000_FF00);
    wr(1'b1, 32'h0000_2000);
    @(negedge clk);
    chk("R5 readback", div_rd, 32'h0000_2000);
  endtask

  task automatic t_rate(input logic [31:0] dv, input int n, input int exp, input string tag);
    wr(1'b1, dv);
    settle();
    ticks(1, n, 1);
    repeat (2) @(negedge clk);
    chk(tag, cnt_m, exp);
  endtask

  task automatic t_latency();
    wr(1'b1, 32'h0000_1000);
    settle();
    src_tick = NS'(2);
    @(negedge clk);
    src_tick = '0;
    chk("R9 pulse one cycle after tick", {31'd0, out_m}, 1);
    @(negedge clk);
    chk("R9 pulse one cycle wide", {31'd0, out_m}, 0);
  endtask

  task automatic t_select();
    wr(1'b1, 32'h0000_2000);
    wr(1'b0, 32'h0000_0011);
    settle();
    ticks(2, 10, 1);
    repeat (2) @(negedge clk);
    chk("R2 unselected ignored", cnt_m, 0);
    wr(1'b0, 32'h0000_0012);
    settle();
    ticks(2, 10, 1);
    repeat (2) @(negedge clk);
    chk("R2 selected source 2", cnt_m, 5);
  endtask

  task automatic t_ground();
    wr(1'b0, 32'h0000_0010);
    settle();
    ticks(0, 10, 1);
    repeat (2) @(negedge clk);
    chk("R8 ground main", cnt_m, 0);
    chk("R8 ground bypass", cnt_b, 0);
  endtask

  task automatic t_disable();
    wr(1'b0, 32'h0000_0001);
    settle();
    chk("R4 run flag clear", ctl_rd, 32'h01);
    ticks(1, 10, 1);
    repeat (2) @(negedge clk);
    chk("R3 disabled main", cnt_m, 0);
    chk("R3 disabled bypass", cnt_b, 0);
  endtask

  task automatic t_same_cycle();
    wr(1'b0, 32'h0000_0011);
    wr(1'b1, 32'h0000_2800);
    settle();
    ticks(1, 2, 1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 32'h0000_2800;
    src_tick = NS'(2);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; src_tick = '0;
    chk("R11 pulse survives write", {31'd0, out_m}, 1);
    @(negedge clk);
    ticks(1, 2, 1);
    repeat (2) @(negedge clk);
    chk("R11 remainder dropped", cnt_m, 1);
    ticks(1, 1, 1);
    repeat (2) @(negedge clk);
    chk("R11 next pulse after clear", cnt_m, 2);
    wr(1'b1, 32'h0000_2800);
    settle();
    ticks(1, 2, 1);
    wr(1'b0, 32'h0000_0012);
    ticks(2, 2, 1);
    repeat (2) @(negedge clk);
    chk("R11 source change clears", cnt_m, 0);
    ticks(2, 1, 1);
    repeat (2) @(negedge clk);
    chk("R11 source change count", cnt_m, 1);
  endtask

  initial begin
    rst_n = 1'b0; src_tick = '0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_zero_div();
    t_fields();
    t_rate(32'h0000_2000, 40, 20, "R9 ratio 2.0");
    t_rate(32'h0000_2800, 40, 16, "R9 ratio 2.5");
    t_rate(32'h0000_1800, 48, 32, "R9 ratio 1.5");
    t_rate(32'h0000_2800, 3, 1, "R9 ratio 2.5 short run");
    t_rate(32'h0000_0800, 10, 10, "R10 ratio 0.5");
    t_latency();
    t_select();
    t_ground();
    t_disable();
    t_same_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule